// File: doc/BRIEF.md
# Power-Failure Recovery Controller

This block sits in the always-powered control domain and follows the supply it is running from. If the battery is the only source, the block is in an outage. During an outage it holds every wake input at its inactive high level. It also stores the current level of the power-on control output and then drives that output off. After the main standby supply returns, the wake inputs stay masked for one more second, counted on a prescaled tick input. At the end of that second the block recovers the system according to a two-bit recovery mode.

The recovery modes are as follows. The first mode restores the stored power-on level, but only when a separate restore bit is set. The second mode leaves the system off until an enabled wake event arrives. The third mode powers the system on if an enabled match event was latched during the outage. Otherwise it waits for a new enabled wake event. The fourth code is reserved and behaves like the stay-off mode. Once the main supply is back, the manual power button can always switch the system on, in any mode.

Top module: `pfr_ctrl`

## Requirements
- R1: After reset the block is in normal operation: `inputs_masked` is 0, `pwr_on` is 0, and `wake_q_n` equals `wake_raw_n`.
- R2: A clock edge with `on_batt` high causes three things from the next cycle on: `inputs_masked` is 1, every bit of `wake_q_n` is 1, and `pwr_on` is 0.
- R3: The level of `pwr_on` is stored at the edge where the block leaves normal operation. A second failure during the holdoff neither overwrites nor extends that stored value.
- R4: After `on_batt` falls, the inputs stay masked until exactly TICKS_PER_SEC `tick` pulses have been seen with `on_batt` low. `inputs_masked` drops in the cycle after the last of those pulses.
- R5: If `on_batt` rises during the holdoff, the block returns to the outage state and the tick count starts again from zero.
- R6: Mode 2'b00 is restore. At the end of the holdoff, `pwr_on` takes the stored level when `restore_en` is 1, and stays 0 when `restore_en` is 0.
- R7: Mode 2'b01 is stay-off. `pwr_on` stays 0 after the holdoff until an enabled wake input is seen.
- R8: Mode 2'b10 is match. At the end of the holdoff, `pwr_on` becomes 1 if a `match_evt` pulse arrived with `match_en` high during the outage. If none arrived, `pwr_on` stays 0 until an enabled wake input is seen.
- R9: Mode 2'b11 is reserved and behaves like mode 2'b01.
- R10: `pwr_btn_n` low sets `pwr_on` on the next edge during the holdoff or normal operation. It is ignored during the outage.
- R11: In normal operation, a wake bit is low and its `wake_en` bit is 1 sets `pwr_on` on the next edge. A low wake bit whose enable is 0 has no effect, and so does any wake input while masked.
- R12: `sw_off` clears `pwr_on` in normal operation. When a turn-on event arrives in the same cycle, the turn-on event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_batt | input | 1 | 1 when running from battery without the main standby supply |
| tick | input | 1 | One-cycle prescaled tick; TICKS_PER_SEC of them make one second |
| wake_raw_n | input | N_WAKE | Raw wake inputs, active low |
| wake_en | input | N_WAKE | Per-input wake enables |
| match_evt | input | 1 | Match event pulse from the alarm comparator |
| match_en | input | 1 | Enables latching of match events during an outage |
| pwr_btn_n | input | 1 | Manual power button, active low |
| sw_off | input | 1 | Software request to turn the system off |
| rec_mode | input | 2 | Recovery mode: 00 restore, 01 stay off, 10 match, 11 reserved |
| restore_en | input | 1 | Restore bit used by mode 00 |
| wake_q_n | output | N_WAKE | Wake inputs after masking, active low |
| inputs_masked | output | 1 | 1 during an outage and during the holdoff |
| pwr_on | output | 1 | Power-on control, active high |

## Verification
The bench builds the block with N_WAKE = 4 and TICKS_PER_SEC = 3. Three ticks make the holdoff short, so each outage, including one that fails again mid-count, finishes in a few dozen cycles. Because the value is greater than one, the counter variant is built rather than the single-tick shortcut. Four wake bits leave room for random enable patterns that mix enabled and disabled lines. Random outages cover all four recovery modes and both restore settings, with the output either on or off before the outage and with or without a match event during it.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_FAIL = 2'd1,
      ST_HOLD = 2'd2
   } pfr_state_e;

   localparam logic [1:0] MODE_RESTORE  = 2'b00;
   localparam logic [1:0] MODE_STAY_OFF = 2'b01;
   localparam logic [1:0] MODE_MATCH    = 2'b10;
   localparam logic [1:0] MODE_RSVD     = 2'b11;

   // Level the recovery policy asks for at the end of the holdoff.
   function automatic logic policy_on(input logic [1:0] mode,
                                      input logic       restore,
                                      input logic       saved,
                                      input logic       match_seen);
      case (mode)
         MODE_RESTORE: policy_on = restore & saved;
         MODE_MATCH:   policy_on = match_seen;
         default:      policy_on = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pfr_supply_fsm.sv
module pfr_supply_fsm
   import pfr_pkg::*;
#(
   parameter int TICKS_PER_SEC = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       on_batt,
   input  logic       tick,
   output pfr_state_e state,
   output logic       recover,
   output logic       masked
);

   pfr_state_e nxt;
   logic       hold_last;

   generate
      if (TICKS_PER_SEC == 1) begin : g_single
         assign hold_last = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(TICKS_PER_SEC);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (state != ST_HOLD || on_batt) begin
               cnt <= '0;
            end else if (tick) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign hold_last = (cnt == LAST);
      end
   endgenerate

   assign recover = (state == ST_HOLD) && !on_batt && tick && hold_last;

   always_comb begin
      nxt = state;
      case (state)
         ST_RUN:  if (on_batt) nxt = ST_FAIL;
         ST_FAIL: if (!on_batt) nxt = ST_HOLD;
         ST_HOLD: begin
            if (on_batt)      nxt = ST_FAIL;
            else if (recover) nxt = ST_RUN;
         end
         default: nxt = ST_FAIL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= nxt;
   end

   assign masked = (state != ST_RUN);

endmodule

// File: rtl/pfr_wake_gate.sv
module pfr_wake_gate #(
   parameter int N_WAKE = 8
) (
   input  logic [N_WAKE-1:0] wake_raw_n,
   input  logic [N_WAKE-1:0] wake_en,
   input  logic              masked,
   output logic [N_WAKE-1:0] wake_q_n,
   output logic              wake_hit
);

   logic [N_WAKE-1:0] hit_v;

   generate
      for (genvar i = 0; i < N_WAKE; i++) begin : g_bit
         assign wake_q_n[i] = wake_raw_n[i] | masked;
         assign hit_v[i]    = ~wake_q_n[i] & wake_en[i];
      end
   endgenerate

   assign wake_hit = |hit_v;

endmodule

// File: rtl/pfr_on_ctrl.sv
module pfr_on_ctrl
   import pfr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pfr_state_e state,
   input  logic       on_batt,
   input  logic       recover,
   input  logic       wake_hit,
   input  logic       btn_n,
   input  logic       sw_off,
   input  logic       match_evt,
   input  logic       match_en,
   input  logic [1:0] mode,
   input  logic       restore_en,
   output logic       pwr_on
);

   logic saved_on;
   logic match_pend;
   logic btn_hit;
   logic turn_on;

   assign btn_hit = !btn_n && (state != ST_FAIL);
   assign turn_on = btn_hit || wake_hit ||
                    (recover && policy_on(mode, restore_en, saved_on, match_pend));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_on <= 1'b0;
      end else if (state == ST_RUN && on_batt) begin
         saved_on <= pwr_on;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pend <= 1'b0;
      end else if ((state == ST_RUN && on_batt) || recover) begin
         match_pend <= 1'b0;
      end else if (state == ST_FAIL && match_evt && match_en) begin
         match_pend <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_on <= 1'b0;
      end else if (on_batt) begin
         pwr_on <= 1'b0;
      end else if (turn_on) begin
         pwr_on <= 1'b1;
      end else if (sw_off && state == ST_RUN) begin
         pwr_on <= 1'b0;
      end
   end

endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
   import pfr_pkg::*;
#(
   parameter int N_WAKE        = 8,
   parameter int TICKS_PER_SEC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_batt,
   input  logic              tick,
   input  logic [N_WAKE-1:0] wake_raw_n,
   input  logic [N_WAKE-1:0] wake_en,
   input  logic              match_evt,
   input  logic              match_en,
   input  logic              pwr_btn_n,
   input  logic              sw_off,
   input  logic [1:0]        rec_mode,
   input  logic              restore_en,
   output logic [N_WAKE-1:0] wake_q_n,
   output logic              inputs_masked,
   output logic              pwr_on
);

   generate
      if (N_WAKE < 1) begin : g_bad_width
         $error("pfr_ctrl: N_WAKE must be at least 1");
      end
      if (TICKS_PER_SEC < 1) begin : g_bad_ticks
         $error("pfr_ctrl: TICKS_PER_SEC must be at least 1");
      end
   endgenerate

   pfr_state_e state;
   logic       recover;
   logic       wake_hit;

   pfr_supply_fsm #(.TICKS_PER_SEC(TICKS_PER_SEC)) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_batt (on_batt),
      .tick    (tick),
      .state   (state),
      .recover (recover),
      .masked  (inputs_masked)
   );

   pfr_wake_gate #(.N_WAKE(N_WAKE)) gate_i (
      .wake_raw_n (wake_raw_n),
      .wake_en    (wake_en),
      .masked     (inputs_masked),
      .wake_q_n   (wake_q_n),
      .wake_hit   (wake_hit)
   );

   pfr_on_ctrl on_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .on_batt    (on_batt),
      .recover    (recover),
      .wake_hit   (wake_hit),
      .btn_n      (pwr_btn_n),
      .sw_off     (sw_off),
      .match_evt  (match_evt),
      .match_en   (match_en),
      .mode       (rec_mode),
      .restore_en (restore_en),
      .pwr_on     (pwr_on)
   );

endmodule

// File: rtl/pfr_ctrl_chk.sv
module pfr_ctrl_chk #(
   parameter int N_WAKE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              on_batt,
   input logic              tick,
   input logic [N_WAKE-1:0] wake_raw_n,
   input logic [N_WAKE-1:0] wake_en,
   input logic              pwr_btn_n,
   input logic [N_WAKE-1:0] wake_q_n,
   input logic              inputs_masked,
   input logic              pwr_on
);

   assert_batt_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      on_batt |=> inputs_masked);

   assert_batt_forces_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      on_batt |=> !pwr_on);

   assert_masked_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inputs_masked |-> (&wake_q_n));

   assert_unmask_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inputs_masked) |-> ($past(tick) && !$past(on_batt)));

   assert_button_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_btn_n && !on_batt && !inputs_masked) |=> pwr_on);

   assert_wake_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!inputs_masked && !on_batt && |(~wake_raw_n & wake_en)) |=> pwr_on);

endmodule

bind pfr_ctrl pfr_ctrl_chk #(.N_WAKE(N_WAKE)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .on_batt       (on_batt),
   .tick          (tick),
   .wake_raw_n    (wake_raw_n),
   .wake_en       (wake_en),
   .pwr_btn_n     (pwr_btn_n),
   .wake_q_n      (wake_q_n),
   .inputs_masked (inputs_masked),
   .pwr_on        (pwr_on)
);

// File: tb/pfr_ctrl_tb_top.sv
module pfr_ctrl_tb_top;

   localparam int NW = 4;
   localparam int TPS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          on_batt = 1'b0;
   logic          tick = 1'b0;
   logic [NW-1:0] wake_raw_n = '1;
   logic [NW-1:0] wake_en = '0;
   logic          match_evt = 1'b0;
   logic          match_en = 1'b0;
   logic          pwr_btn_n = 1'b1;
   logic          sw_off = 1'b0;
   logic [1:0]    rec_mode = 2'b00;
   logic          restore_en = 1'b0;
   logic [NW-1:0] wake_q_n;
   logic          inputs_masked;
   logic          pwr_on;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   pfr_ctrl #(.N_WAKE(NW), .TICKS_PER_SEC(TPS)) dut_i (
      .clk(clk), .rst_n(rst_n), .on_batt(on_batt), .tick(tick),
      .wake_raw_n(wake_raw_n), .wake_en(wake_en), .match_evt(match_evt),
      .match_en(match_en), .pwr_btn_n(pwr_btn_n), .sw_off(sw_off),
      .rec_mode(rec_mode), .restore_en(restore_en), .wake_q_n(wake_q_n),
      .inputs_masked(inputs_masked), .pwr_on(pwr_on)
   );

   function automatic logic exp_on(input logic [1:0] mode, input logic restore,
                                   input logic saved, input logic matched);
      if (mode == 2'b00) return restore & saved;
      if (mode == 2'b10) return matched;
      return 1'b0;
   endfunction

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_level(input logic lvl);
      if (lvl) pwr_btn_n = 1'b0; else sw_off = 1'b1;
      cyc();
      pwr_btn_n = 1'b1; sw_off = 1'b0;
   endtask

   task automatic hold_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1; cyc(); tick = 1'b0; cyc();
      end
   endtask

   task automatic outage(input logic [1:0] mode, input logic restore,
                         input logic pre_on, input logic matched);
      rec_mode = mode; restore_en = restore; match_en = 1'b1;
      set_level(pre_on);
      chk(pre_on ? "R10" : "R12", pwr_on, pre_on);
      on_batt = 1'b1; wake_raw_n = NW'($urandom); cyc();
      chk("R2", {inputs_masked, pwr_on, wake_q_n}, {2'b10, {NW{1'b1}}});
      if (matched) begin match_evt = 1'b1; cyc(); match_evt = 1'b0; end
      wake_raw_n = '1;
      on_batt = 1'b0; cyc();
      hold_ticks(TPS - 1);
      chk("R4", inputs_masked, 1'b1);
      hold_ticks(1);
      chk("R4", inputs_masked, 1'b0);
      // R6 R7 R8 R9
      chk(mode == 2'b00 ? "R6" : mode == 2'b01 ? "R7" : mode == 2'b10 ? "R8" : "R9",
          pwr_on, exp_on(mode, restore, pre_on, matched));
      if (!pwr_on) begin
         int j = int'($urandom_range(NW - 1));
         wake_en = '0; wake_en[j] = 1'b1; wake_raw_n[j] = 1'b0; cyc();
         chk(mode == 2'b11 ? "R9" : mode == 2'b10 ? "R8" : "R7", pwr_on, 1'b1);
         wake_raw_n = '1; wake_en = '0;
      end
      match_en = 1'b0;
   endtask

   initial begin
      #20000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357));
      cyc(); cyc();
      wake_raw_n = 4'b1010;
      cyc();
      chk("R1", {inputs_masked, pwr_on, wake_q_n}, {2'b00, 4'b1010});
      rst_n = 1'b1; wake_raw_n = '1; cyc();
      chk("R1", {inputs_masked, pwr_on}, 2'b00);

      // R11: disabled wake ignored, enabled wake turns on
      wake_en = 4'b0001; wake_raw_n = 4'b1101; cyc();
      chk("R11", pwr_on, 1'b0);
      wake_raw_n = 4'b1110; cyc();
      chk("R11", pwr_on, 1'b1);
      wake_raw_n = '1;

      // R12: turn-on wins over sw_off in the same cycle
      sw_off = 1'b1; pwr_btn_n = 1'b0; cyc();
      chk("R12", pwr_on, 1'b1);
      pwr_btn_n = 1'b1; cyc();
      chk("R12", pwr_on, 1'b0);
      sw_off = 1'b0;

      // R3 R5: outage with pwr_on high, fail again mid-holdoff, restore mode
      rec_mode = 2'b00; restore_en = 1'b1;
      set_level(1'b1);
      on_batt = 1'b1; cyc();
      // R10: button ignored during outage; R11: enabled wake masked
      pwr_btn_n = 1'b0; wake_raw_n = 4'b1110; cyc();
      chk("R10", pwr_on, 1'b0);
      pwr_btn_n = 1'b1; wake_raw_n = '1;
      on_batt = 1'b0; cyc();
      hold_ticks(TPS - 1);
      on_batt = 1'b1; cyc(); on_batt = 1'b0; cyc();
      hold_ticks(TPS - 1);
      chk("R5", inputs_masked, 1'b1);
      hold_ticks(1);
      chk("R5", inputs_masked, 1'b0);
      chk("R3", pwr_on, 1'b1);

      // R10: button works during holdoff
      rec_mode = 2'b01;
      on_batt = 1'b1; cyc(); on_batt = 1'b0; cyc();
      pwr_btn_n = 1'b0; cyc(); pwr_btn_n = 1'b1;
      chk("R10", {inputs_masked, pwr_on}, 2'b11);
      hold_ticks(TPS);
      chk("R10", {inputs_masked, pwr_on}, 2'b01);
      wake_en = '0;

      // Directed: every mode with pre-on high
      for (int m = 0; m < 4; m++) outage(2'(m), 1'b1, 1'b1, 1'b0);
      outage(2'b10, 1'b0, 1'b0, 1'b1);
      outage(2'b00, 1'b0, 1'b1, 1'b1);

      // Random outages
      for (int it = 0; it < 40; it++)
         outage(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule